// File: doc/BRIEF.md
# SAR Converter Self-Calibration Sequencer

This block is the digital controller that measures the size error of the five most significant capacitors in the capacitive DAC of a 16-bit successive-approximation converter. The DAC word is split into a top bank of five bits (15 down to 11) and eleven lower bits (10 down to 0). Only the top-bank capacitors are measured. For each of them the controller runs a fixed three-phase conversion:

- **Precharge:** the lower capacitors sit on the high reference while the top plate is held at the supply.
- **Share:** the top plate floats and only the capacitor under test is switched high, so that charge redistributes.
- **Search:** an 11-step binary search over the lower capacitors, one step per lower bit, driven by the comparator.

Each measurement repeats the conversion 2^AVG_LOG2 times and averages the results. The sequence covers bits 11 to 15 on the plus-side DAC and then bits 11 to 15 on the minus-side DAC. The ten signed results, in units of 16-bit LSBs, are held in output registers for firmware to fold into its correction terms.

The block is used with a single-cycle `start` request, a `busy` level for the whole run and a one-cycle `done` pulse. The analog array follows `dac_sel`, `top_hold` and `side_minus`, and returns a single comparator decision, `cmp_keep`.

Top module: `sar_cal_seq`

## Requirements
- R1: A `start` is accepted only when the block is idle, meaning neither `busy` nor `done` is high. A `start` seen while `busy` or during the `done` cycle has no effect on any output.
- R2: After an accepted `start`, `busy` rises on the next clock edge and stays high for exactly 2 × N_MSB × 2^AVG_LOG2 × (N_SUB + 2) cycles. It then falls as `done` goes high for exactly one cycle. `busy` and `done` are never high together.
- R3: Measurements run on the plus side first (`side_minus` = 0) and then on the minus side (`side_minus` = 1). Within a side they go from DAC bit 11 up to bit 15, with all 2^AVG_LOG2 conversions of one capacitor back to back. While not busy, `dac_sel` is all zero and `top_hold` is low.
- R4: The first cycle of every conversion is the precharge cycle. `top_hold` is 1 and `dac_sel` has bits 10..0 set and bits 15..11 clear (a `dac_sel` bit of 1 means high reference). `top_hold` is 0 in every other cycle.
- R5: The second cycle of every conversion is the share cycle. `top_hold` is 0 and the only bit set in `dac_sel` is the bit of the capacitor under test.
- R6: The next N_SUB cycles are the search. In step j (j = 0..10), `dac_sel[10:0]` shows the bits already kept plus a trial bit at position 10−j, and the capacitor under test stays set. A high `cmp_keep` in that cycle keeps the trial bit.
- R7: Each conversion yields `code − 1024`, where `code` is the 11-bit search result. The 2^AVG_LOG2 values are summed in a 16-bit signed accumulator and shifted right arithmetically by AVG_LOG2, so the result rounds toward minus infinity.
- R8: Results are stored as 8-bit two's-complement values saturated to the range −128..127. The field for DAC bit 11+k occupies bits [8k+7:8k] of `err_plus` or `err_minus`.
- R9: Reset clears all result fields to zero. A field keeps its value until its own measurement finishes in a later run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request to begin a calibration run |
| cmp_keep | input | 1 | Comparator decision: keep the current trial bit |
| busy | output | 1 | Calibration run in progress |
| done | output | 1 | One-cycle completion pulse |
| top_hold | output | 1 | Hold the top-bank top plate at the supply (precharge) |
| side_minus | output | 1 | 0 = plus-side DAC under test, 1 = minus-side |
| dac_sel | output | 16 | Bottom-plate reference select per DAC bit, 1 = high |
| err_plus | output | 40 | Plus-side results, five signed 8-bit fields |
| err_minus | output | 40 | Minus-side results, five signed 8-bit fields |

## Verification
The bench builds the block with its default geometry (five top bits, eleven lower bits, 8-bit results) and AVG_LOG2 = 5, so every result comes from a full 32-conversion average. A behavioural comparator adds a repeating per-conversion offset of −1..+2 to each capacitor's true error. With that offset, the half-LSB floor of negative averages becomes visible. Error tables of ±200 drive the saturation limits from both sides, and values of 127 and −128 land exactly on the limits. Extra `start` pulses in the middle of a run and on the `done` cycle exercise the gating.

// File: rtl/sar_cal_pkg.sv
// Shared types of the calibration sequencer.
// Assumes nothing beyond a single clock domain.
package sar_cal_pkg;
    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SAMPLE,
        PH_REDIST,
        PH_SEARCH,
        PH_DONE
    } phase_t;
endpackage

// File: rtl/sar_cal_ctrl.sv
// Phase sequencer: walks the side, capacitor, conversion and search-step
// counters for one full calibration run.
// Assumes N_SUB >= 2 and N_MSB >= 2; start is a level sampled on each clock.
module sar_cal_ctrl #(
    parameter int N_MSB    = 5,
    parameter int N_SUB    = 11,
    parameter int AVG_LOG2 = 5,
    localparam int IDX_W  = $clog2(N_MSB),
    localparam int BIT_W  = $clog2(N_SUB),
    localparam int CONV_W = (AVG_LOG2 > 0) ? AVG_LOG2 : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    output sar_cal_pkg::phase_t  phase,
    output logic [BIT_W-1:0]     bit_pos,
    output logic [IDX_W-1:0]     cap,
    output logic                 side,
    output logic                 conv_first,
    output logic                 conv_end,
    output logic                 meas_end
);
    import sar_cal_pkg::*;

    localparam int NCONV = 1 << AVG_LOG2;
    localparam logic [CONV_W-1:0] CONV_LAST = CONV_W'(NCONV - 1);
    localparam logic [IDX_W-1:0]  CAP_LAST  = IDX_W'(N_MSB - 1);
    localparam logic [BIT_W-1:0]  BIT_TOP   = BIT_W'(N_SUB - 1);

    logic [CONV_W-1:0] conv;

    // Decode the per-conversion and per-measurement boundaries.
    always_comb begin
        conv_first = (conv == '0);
        conv_end   = (phase == PH_SEARCH) && (bit_pos == '0);
        meas_end   = conv_end && (conv == CONV_LAST);
    end

    // Advance the phase and the nested run counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase   <= PH_IDLE;
            bit_pos <= '0;
            cap     <= '0;
            side    <= 1'b0;
            conv    <= '0;
        end else begin
            unique case (phase)
                PH_IDLE: begin
                    if (start) begin
                        phase <= PH_SAMPLE;
                        cap   <= '0;
                        side  <= 1'b0;
                        conv  <= '0;
                    end
                end
                PH_SAMPLE: phase <= PH_REDIST;
                PH_REDIST: begin
                    phase   <= PH_SEARCH;
                    bit_pos <= BIT_TOP;
                end
                PH_SEARCH: begin
                    if (bit_pos != '0) begin
                        bit_pos <= bit_pos - 1'b1;
                    end else if (conv != CONV_LAST) begin
                        conv  <= conv + 1'b1;
                        phase <= PH_SAMPLE;
                    end else begin
                        conv <= '0;
                        if (cap != CAP_LAST) begin
                            cap   <= cap + 1'b1;
                            phase <= PH_SAMPLE;
                        end else if (!side) begin
                            side  <= 1'b1;
                            cap   <= '0;
                            phase <= PH_SAMPLE;
                        end else begin
                            phase <= PH_DONE;
                        end
                    end
                end
                PH_DONE: phase <= PH_IDLE;
                default: phase <= PH_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/sar_cal_search.sv
// Binary-search register over the lower capacitors: presents the trial word
// and keeps or drops the trial bit on each comparator decision.
// Assumes clear comes in the cycle before the first search step.
module sar_cal_search #(
    parameter int N_SUB = 11,
    localparam int BIT_W = $clog2(N_SUB)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             active,
    input  logic [BIT_W-1:0] bit_pos,
    input  logic             cmp_keep,
    output logic [N_SUB-1:0] trial,
    output logic [N_SUB-1:0] code_final
);
    logic [N_SUB-1:0] code;
    logic [N_SUB-1:0] onehot;

    // Form the trial word and the word including this step's decision.
    always_comb begin
        onehot     = N_SUB'(1) << bit_pos;
        trial      = active ? (code | onehot) : '0;
        code_final = code | (cmp_keep ? onehot : '0);
    end

    // Hold the decided bits of the conversion in progress.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            code <= '0;
        end else if (active && cmp_keep) begin
            code <= code | onehot;
        end
    end
endmodule

// File: rtl/sar_cal_avg.sv
// Averager: turns each search code into a signed offset from mid-scale,
// sums a group of conversions, shifts and saturates the result.
// Assumes ACC_W holds 2^AVG_LOG2 offsets of N_SUB bits without overflow.
module sar_cal_avg #(
    parameter int N_SUB    = 11,
    parameter int AVG_LOG2 = 5,
    parameter int ACC_W    = 16,
    parameter int ERR_W    = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             conv_end,
    input  logic             conv_first,
    input  logic [N_SUB-1:0] code,
    output logic [ERR_W-1:0] result
);
    localparam logic signed [ACC_W-1:0] MID    = ACC_W'(1 << (N_SUB - 1));
    localparam logic signed [ACC_W-1:0] SAT_HI = ACC_W'((1 << (ERR_W - 1)) - 1);
    localparam logic signed [ACC_W-1:0] SAT_LO = ~SAT_HI;

    logic signed [ACC_W-1:0] acc;
    logic signed [ACC_W-1:0] offs;
    logic signed [ACC_W-1:0] sum_next;
    logic signed [ACC_W-1:0] scaled;

    // Compute the running sum, the averaged value and its saturated form.
    always_comb begin
        offs     = $signed(ACC_W'(code)) - MID;
        sum_next = (conv_first ? '0 : acc) + offs;
        scaled   = sum_next >>> AVG_LOG2;
        if (scaled > SAT_HI) begin
            result = SAT_HI[ERR_W-1:0];
        end else if (scaled < SAT_LO) begin
            result = SAT_LO[ERR_W-1:0];
        end else begin
            result = scaled[ERR_W-1:0];
        end
    end

    // Register the sum at the end of each conversion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc <= '0;
        end else if (conv_end) begin
            acc <= sum_next;
        end
    end
endmodule

// File: rtl/sar_cal_store.sv
// Result register file: one signed field per measured capacitor per side.
// Assumes wr is a single-cycle strobe with side and cap valid alongside.
module sar_cal_store #(
    parameter int N_MSB = 5,
    parameter int ERR_W = 8,
    localparam int IDX_W = $clog2(N_MSB)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr,
    input  logic                   side,
    input  logic [IDX_W-1:0]       cap,
    input  logic [ERR_W-1:0]       data,
    output logic [N_MSB*ERR_W-1:0] err_plus,
    output logic [N_MSB*ERR_W-1:0] err_minus
);
    for (genvar g = 0; g < N_MSB; g++) begin : g_field
        // Capture the averaged result into this capacitor's field.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                err_plus[g*ERR_W +: ERR_W]  <= '0;
                err_minus[g*ERR_W +: ERR_W] <= '0;
            end else if (wr && cap == IDX_W'(g)) begin
                if (side) begin
                    err_minus[g*ERR_W +: ERR_W] <= data;
                end else begin
                    err_plus[g*ERR_W +: ERR_W] <= data;
                end
            end
        end
    end
endmodule

// File: rtl/sar_cal_seq.sv
// Top of the self-calibration sequencer. It ties the phase sequencer,
// search register, averager and result store together and decodes the
// DAC switch word. Assumes the comparator decision is valid within the
// search cycle in which the trial word is shown.
module sar_cal_seq #(
    parameter int N_MSB    = 5,
    parameter int N_SUB    = 11,
    parameter int AVG_LOG2 = 5,
    parameter int ACC_W    = 16,
    parameter int ERR_W    = 8,
    localparam int DAC_W = N_MSB + N_SUB,
    localparam int IDX_W = $clog2(N_MSB),
    localparam int BIT_W = $clog2(N_SUB)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic                   cmp_keep,
    output logic                   busy,
    output logic                   done,
    output logic                   top_hold,
    output logic                   side_minus,
    output logic [DAC_W-1:0]       dac_sel,
    output logic [N_MSB*ERR_W-1:0] err_plus,
    output logic [N_MSB*ERR_W-1:0] err_minus
);
    import sar_cal_pkg::*;

    phase_t           phase;
    logic [BIT_W-1:0] bit_pos;
    logic [IDX_W-1:0] cap;
    logic             side;
    logic             conv_first;
    logic             conv_end;
    logic             meas_end;
    logic [N_SUB-1:0] trial;
    logic [N_SUB-1:0] code_final;
    logic [ERR_W-1:0] result;
    logic [N_MSB-1:0] cut_mask;

    sar_cal_ctrl #(.N_MSB(N_MSB), .N_SUB(N_SUB), .AVG_LOG2(AVG_LOG2)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .phase(phase),
        .bit_pos(bit_pos), .cap(cap), .side(side), .conv_first(conv_first),
        .conv_end(conv_end), .meas_end(meas_end)
    );

    sar_cal_search #(.N_SUB(N_SUB)) u_search (
        .clk(clk), .rst_n(rst_n), .clear(phase == PH_SAMPLE),
        .active(phase == PH_SEARCH), .bit_pos(bit_pos), .cmp_keep(cmp_keep),
        .trial(trial), .code_final(code_final)
    );

    sar_cal_avg #(.N_SUB(N_SUB), .AVG_LOG2(AVG_LOG2), .ACC_W(ACC_W), .ERR_W(ERR_W)) u_avg (
        .clk(clk), .rst_n(rst_n), .conv_end(conv_end), .conv_first(conv_first),
        .code(code_final), .result(result)
    );

    sar_cal_store #(.N_MSB(N_MSB), .ERR_W(ERR_W)) u_store (
        .clk(clk), .rst_n(rst_n), .wr(meas_end), .side(side), .cap(cap),
        .data(result), .err_plus(err_plus), .err_minus(err_minus)
    );

    // Decode handshake levels and the reference switch word from the phase.
    always_comb begin
        cut_mask   = N_MSB'(1) << cap;
        busy       = (phase == PH_SAMPLE) || (phase == PH_REDIST) || (phase == PH_SEARCH);
        done       = (phase == PH_DONE);
        top_hold   = (phase == PH_SAMPLE);
        side_minus = busy && side;
        dac_sel    = '0;
        unique case (phase)
            PH_SAMPLE: dac_sel[N_SUB-1:0]     = '1;
            PH_REDIST: dac_sel[DAC_W-1:N_SUB] = cut_mask;
            PH_SEARCH: dac_sel                = {cut_mask, trial};
            default:   dac_sel                = '0;
        endcase
    end
endmodule

// File: rtl/sar_cal_checker.sv
// Protocol checker for the calibration sequencer, attached by bind.
// Assumes the same parameter values as the instance it is bound to.
module sar_cal_checker #(
    parameter int N_MSB    = 5,
    parameter int N_SUB    = 11,
    parameter int ERR_W    = 8,
    localparam int DAC_W = N_MSB + N_SUB
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   start,
    input logic                   busy,
    input logic                   done,
    input logic                   top_hold,
    input logic [DAC_W-1:0]       dac_sel,
    input logic [N_MSB*ERR_W-1:0] err_plus,
    input logic [N_MSB*ERR_W-1:0] err_minus
);
    assert_start_gate_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> ($past(start) && !$past(done)));

    assert_busy_done_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));

    assert_done_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_idle_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (dac_sel == '0 && !top_hold));

    assert_precharge_word_R4: assert property (@(posedge clk) disable iff (!rst_n)
        top_hold |-> (dac_sel == {{N_MSB{1'b0}}, {N_SUB{1'b1}}}));

    assert_share_follows_R5: assert property (@(posedge clk) disable iff (!rst_n)
        top_hold |=> (!top_hold && dac_sel[N_SUB-1:0] == '0
                      && $countones(dac_sel[DAC_W-1:N_SUB]) == 1));

    assert_cut_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !top_hold) |-> ($countones(dac_sel[DAC_W-1:N_SUB]) == 1));

    assert_results_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> ($stable(err_plus) && $stable(err_minus)));
endmodule

bind sar_cal_seq sar_cal_checker #(.N_MSB(N_MSB), .N_SUB(N_SUB), .ERR_W(ERR_W)) u_chk (.*);

// File: tb/sar_cal_seq_test.sv
// Bench for the calibration sequencer: a behavioural model predicts every
// output cycle by cycle, and a comparator model supplies the decisions.
module sar_cal_seq_test;
    localparam int CLK_PERIOD = 10;
    localparam int AVG   = 5;
    localparam int NC    = 1 << AVG;
    localparam int CONVC = 13;
    localparam int TOTAL = 2 * 5 * NC * CONVC;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        cmp_keep;
    logic        busy, done, top_hold, side_minus;
    logic [15:0] dac_sel;
    logic [39:0] err_plus, err_minus;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;
    bit run_chk = 1'b0;

    int e_tab [2][5];
    bit m_busy = 1'b0;
    bit m_done = 1'b0;
    int m_cnt = 0;
    int cur_t;

    sar_cal_seq #(.AVG_LOG2(AVG)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .cmp_keep(cmp_keep),
        .busy(busy), .done(done), .top_hold(top_hold), .side_minus(side_minus),
        .dac_sel(dac_sel), .err_plus(err_plus), .err_minus(err_minus)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    function automatic int tgt(int s, int k, int c);
        int v;
        v = 1024 + e_tab[s][k] + (c % 4) - 1;
        if (v < 0) v = 0;
        if (v > 2047) v = 2047;
        return v;
    endfunction

    function automatic int exp_err(int s, int k);
        int sum;
        int avg;
        sum = 0;
        for (int c = 0; c < NC; c++) sum += tgt(s, k, c) - 1024;
        avg = sum >>> AVG;
        if (avg > 127) avg = 127;
        if (avg < -128) avg = -128;
        return avg;
    endfunction

    // Target code of the conversion the model is in.
    always_comb begin
        int g;
        int meas;
        g = m_cnt / CONVC;
        meas = g / NC;
        cur_t = tgt(meas / 5, meas % 5, g % NC);
    end

    assign cmp_keep = m_busy && ((m_cnt % CONVC) >= 2) && (int'(dac_sel[10:0]) <= cur_t);

    // Reference model of the run timing.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy <= 1'b0;
            m_done <= 1'b0;
            m_cnt  <= 0;
        end else if (!m_busy && !m_done && start) begin
            m_busy <= 1'b1;
            m_cnt  <= 0;
        end else if (m_busy) begin
            if (m_cnt == TOTAL - 1) begin
                m_busy <= 1'b0;
                m_done <= 1'b1;
            end else begin
                m_cnt <= m_cnt + 1;
            end
        end else begin
            m_done <= 1'b0;
        end
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
        end
    endtask

    function automatic int exp_dac();
        int ph, meas, k, cut, b, above;
        if (!m_busy) return 0;
        ph = m_cnt % CONVC;
        meas = (m_cnt / CONVC) / NC;
        k = meas % 5;
        cut = 1 << (11 + k);
        if (ph == 0) return 'h7FF;
        if (ph == 1) return cut;
        b = 10 - (ph - 2);
        above = cur_t & (2047 & ~((1 << (b + 1)) - 1));
        return cut | above | (1 << b);
    endfunction

    // Per-cycle comparison of every control output against the model.
    always @(negedge clk) begin
        if (rst_n && run_chk) begin
            int ph, side_e, d_e;
            string rq;
            ph = m_cnt % CONVC;
            side_e = m_busy ? ((m_cnt / CONVC) / NC) / 5 : 0;
            chk(busy == m_busy, "R2 busy", busy, m_busy);
            chk(done == m_done, "R2 done", done, m_done);
            chk(side_minus == side_e[0], "R3 side", side_minus, side_e);
            chk(top_hold == (m_busy && ph == 0), "R4 top_hold", top_hold, m_busy && ph == 0);
            d_e = exp_dac();
            if (!m_busy) rq = "R3 dac idle";
            else if (ph == 0) rq = "R4 dac precharge";
            else if (ph == 1) rq = "R5 dac share";
            else rq = "R6 dac search";
            chk(int'(dac_sel) == d_e, rq, dac_sel, d_e);
        end
    end

    task automatic check_results(input string req);
        for (int k = 0; k < 5; k++) begin
            chk($signed(err_plus[k*8 +: 8]) == exp_err(0, k), req,
                $signed(err_plus[k*8 +: 8]), exp_err(0, k));
            chk($signed(err_minus[k*8 +: 8]) == exp_err(1, k), req,
                $signed(err_minus[k*8 +: 8]), exp_err(1, k));
        end
    endtask

    // Start a run, poke start mid-run and on the done cycle, wait to idle.
    task automatic do_run(input bit probe_hold);
        int saved [5];
        for (int k = 0; k < 5; k++) saved[k] = $signed(err_minus[k*8 +: 8]);
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        repeat (100) @(negedge clk);
        start = 1'b1;                       // R1: ignored while busy
        @(negedge clk) start = 1'b0;
        if (probe_hold) begin
            for (int k = 0; k < 5; k++)     // R9: minus fields not yet rewritten
                chk($signed(err_minus[k*8 +: 8]) == saved[k], "R9 hold",
                    $signed(err_minus[k*8 +: 8]), saved[k]);
        end
        while (!m_done) @(negedge clk);
        start = 1'b1;                       // R1: ignored during done
        @(negedge clk) start = 1'b0;
        repeat (5) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9: reset state
        chk(busy == 1'b0 && done == 1'b0, "R9 reset handshake", {busy, done}, 0);
        chk(err_plus == '0 && err_minus == '0, "R9 reset results", err_plus | err_minus, 0);
        chk(dac_sel == '0, "R3 reset dac", dac_sel, 0);
        run_chk = 1'b1;

        e_tab[0] = '{3, -2, 5, 0, -7};
        e_tab[1] = '{1, 4, -6, 10, -3};
        do_run(1'b1);
        check_results("R7 averaged result");
        repeat (20) @(negedge clk);
        check_results("R9 hold while idle");

        e_tab[0] = '{200, -200, 127, -128, 0};
        e_tab[1] = '{-300, 300, 126, -127, 1};
        do_run(1'b1);
        check_results("R8 saturation");

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule